// File: doc/BRIEF.md
# Rotating Register Window Controller

This block owns a physical register file of `NAREG` words and exposes sixteen of them at a time as a sliding window. A base pointer, counted in groups of four registers, says where the window starts. A bitmap with one bit per group records which groups hold a live call frame. Window register `r` always names physical register `(base*4 + r) mod NAREG`, so moving the window is only a change of the base pointer. No data is copied.

The surrounding pipeline sends one window operation per cycle with `op_valid` and an opcode, together with the processor-status bits that gate it. The operations are call entry, overflow probe, windowed return, relative rotate, absolute base set, restore of a saved base, and stack-move probe. One cycle later the block gives one result strobe. The strobe carries an event code for an illegal instruction, a spill of 4, 8 or 12 registers, a fill of 4, 8 or 12 registers, or an alloca fault. It also carries the return PC, the faulting PC, the base to be saved in the status word, and a request to set exception mode. The spill and fill handlers live elsewhere. A plain read port and write port reach the file through the current window.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the base is 0, the live-frame bitmap is 1 (only group 0 set), every physical register reads 0, and `res_valid` is 0.
- R2: The read and write ports address window register `r` as physical register `(base*4 + r) mod NAREG`, wrapping past the last register to register 0.
- R3: Call entry (opcode 1) is illegal when `op_sel` > 3, or when it is not true that `ps_woe`=1 and `ps_excm`=0. It then gives event 1 (illegal) and leaves the base, the bitmap and the file unchanged.
- R4: A legal call entry writes `reg[op_sel] - (op_imm<<3)` into window register `{ps_callinc, op_sel[1:0]}`, addressed through the old base. It then adds `ps_callinc` to the base and sets the bitmap bit of the new base.
- R5: The overflow probe (opcode 2, width `w = op_amt[1:0]`) gives event 0 and changes nothing when the window condition fails. It does the same when none of the bitmap bits at base+1 .. base+w (mod NAREG/4) is set.
- R6: When the probe finds its first set bit at offset n, the base becomes m = base+n and `owb_out` gives the old base. The event is 2 (spill 4) if bit m+1 is set, else 3 (spill 8) if bit m+2 is set, else 4 (spill 12).
- R7: Windowed return (opcode 3) takes n = a0[31:30] and takes m as 1, 2 or 3 for the first set bit among base-1, base-2, base-3 (0 when none is set). It gives event 1 when n=0, when m≠0 and m≠n, or when the window condition fails, and it changes no state.
- R8: A legal return gives `ret_pc = {op_pc[31:30], a0[29:0]}` and subtracts n from the base. If the new base's bit is set, the old base's bit is cleared and the event is 0. Otherwise the event is 4+n (fill 4/8/12) and `owb_out` gives the old base.
- R9: Rotate (opcode 4) adds `op_amt` to the base modulo NAREG/4. Set-base (opcode 5) loads `op_amt`. Restore (opcode 6) loads `ps_owb`. None of them touches the bitmap.
- R10: The stack-move probe (opcode 7) gives event 8 (alloca) when the bitmap bits at base-1, base-2 and base-3 are all clear, and event 0 otherwise.
- R11: Each accepted operation gives exactly one `res_valid` pulse in the next cycle, opcode 0 being a no-op with event 0. `set_excm` is 1 and `epc_out` holds `op_pc` exactly when the event is nonzero. Otherwise both are 0, and `ret_pc` and `owb_out` are 0 whenever R8 or R6/R8 do not drive them.
- R12: A port write in the same cycle as a call entry is addressed through the base before the operation. When both hit the same physical register, the entry's value is kept. The entry and a return read register values from before either write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation accepted this cycle |
| op_code | input | 3 | Operation select (encoding in R3–R11) |
| op_sel | input | 4 | Stack register selector for call entry |
| op_imm | input | IMMW | Frame size immediate for call entry |
| op_amt | input | GW | Probe width, rotate delta or absolute base |
| op_pc | input | XLEN | PC of the operation |
| ps_woe | input | 1 | Status: window overflow enable |
| ps_excm | input | 1 | Status: exception mode |
| ps_callinc | input | 2 | Status: call increment |
| ps_owb | input | GW | Status: saved old base |
| wr_en | input | 1 | Window register write enable |
| wr_idx | input | 4 | Window register written |
| wr_data | input | XLEN | Write data |
| rd_idx | input | 4 | Window register read |
| rd_data | output | XLEN | Read data (combinational) |
| res_valid | output | 1 | Result strobe |
| ev_code | output | 4 | Event code |
| ret_pc | output | XLEN | Return PC of a legal return |
| epc_out | output | XLEN | PC to save on an event |
| set_excm | output | 1 | Request to set exception mode |
| owb_out | output | GW | Old base to save on spill or fill |
| window_base | output | GW | Current base pointer |
| window_start | output | NAREG/4 | Live-frame bitmap |

## Verification
A port write and a call entry can target the same register in the same cycle. The entry's destination is computed through the base before rotation, so both can resolve to one physical register. The bench provokes this directly by steering `wr_idx` onto `{ps_callinc, op_sel}`, and it provokes it at random by leaving the port write running during random operations. The outcome is judged by reading the register back through the rotated window. It must hold the entry's value, and the entry's source operand must be the value from before the write.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ENTRY   = 3'd1,
        OP_OVCHK   = 3'd2,
        OP_RETW    = 3'd3,
        OP_ROTW    = 3'd4,
        OP_SETBASE = 3'd5,
        OP_RESTORE = 3'd6,
        OP_MOVSP   = 3'd7
    } win_op_e;

    typedef enum logic [3:0] {
        EV_NONE    = 4'd0,
        EV_ILLEGAL = 4'd1,
        EV_OVF4    = 4'd2,
        EV_OVF8    = 4'd3,
        EV_OVF12   = 4'd4,
        EV_UNF4    = 4'd5,
        EV_UNF8    = 4'd6,
        EV_UNF12   = 4'd7,
        EV_ALLOCA  = 4'd8
    } win_ev_e;

    function automatic logic ev_is_exc(win_ev_e ev);
        return ev != EV_NONE;
    endfunction

    function automatic win_ev_e ev_fill(logic [1:0] n);
        case (n)
            2'd1:    return EV_UNF4;
            2'd2:    return EV_UNF8;
            default: return EV_UNF12;
        endcase
    endfunction

    function automatic win_ev_e ev_spill(logic near1, logic near2);
        if (near1)      return EV_OVF4;
        else if (near2) return EV_OVF8;
        else            return EV_OVF12;
    endfunction

endpackage

// File: rtl/regwin_map.sv
module regwin_map #(
    parameter int NAREG = 64,
    localparam int GW = $clog2(NAREG / 4),
    localparam int PW = $clog2(NAREG)
) (
    input  logic [GW-1:0] base,
    input  logic [3:0]    widx,
    output logic [PW-1:0] pidx
);
    always_comb begin
        pidx = {base, 2'b00} + PW'(widx);
    end
endmodule

// File: rtl/regwin_rel.sv
module regwin_rel #(
    parameter int NGRP = 16,
    localparam int GW = $clog2(NGRP)
) (
    input  logic [NGRP-1:0] ws,
    input  logic [GW-1:0]   base,
    output logic [NGRP-1:0] rel
);
    logic [2*NGRP-1:0] dbl;
    always_comb begin
        dbl = {ws, ws} >> base;
        rel = dbl[NGRP-1:0];
    end
endmodule

// File: rtl/regwin_file.sv
module regwin_file #(
    parameter int NAREG = 64,
    parameter int XLEN  = 32,
    parameter int NRD   = 3,
    localparam int PW = $clog2(NAREG)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NRD-1:0][PW-1:0]    raddr,
    output logic [NRD-1:0][XLEN-1:0]  rdata,
    input  logic                      we_lo,
    input  logic [PW-1:0]             wa_lo,
    input  logic [XLEN-1:0]           wd_lo,
    input  logic                      we_hi,
    input  logic [PW-1:0]             wa_hi,
    input  logic [XLEN-1:0]           wd_hi
);
    logic [XLEN-1:0] mem [NAREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NAREG; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (we_lo) begin
                mem[wa_lo] <= wd_lo;
            end
            if (we_hi) begin
                mem[wa_hi] <= wd_hi;
            end
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
    import regwin_pkg::*;
#(
    parameter int NAREG = 64,
    parameter int XLEN  = 32,
    parameter int IMMW  = 12,
    localparam int NGRP = NAREG / 4,
    localparam int GW   = $clog2(NGRP),
    localparam int PW   = $clog2(NAREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [3:0]        op_sel,
    input  logic [IMMW-1:0]   op_imm,
    input  logic [GW-1:0]     op_amt,
    input  logic [XLEN-1:0]   op_pc,
    input  logic              ps_woe,
    input  logic              ps_excm,
    input  logic [1:0]        ps_callinc,
    input  logic [GW-1:0]     ps_owb,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [XLEN-1:0]   wr_data,
    input  logic [3:0]        rd_idx,
    output logic [XLEN-1:0]   rd_data,
    output logic              res_valid,
    output logic [3:0]        ev_code,
    output logic [XLEN-1:0]   ret_pc,
    output logic [XLEN-1:0]   epc_out,
    output logic              set_excm,
    output logic [GW-1:0]     owb_out,
    output logic [GW-1:0]     window_base,
    output logic [NGRP-1:0]   window_start
);
    localparam int NMAP = 5;
    localparam int M_RD = 0, M_WR = 1, M_SRC = 2, M_DST = 3, M_A0 = 4;

    logic [GW-1:0]   base_q, base_n;
    logic [NGRP-1:0] ws_q, ws_n, rel;
    logic [3:0]      map_w [NMAP];
    logic [PW-1:0]   map_p [NMAP];
    logic [2:0][PW-1:0]   f_raddr;
    logic [2:0][XLEN-1:0] f_rdata;
    logic [XLEN-1:0] src_val, a0_val, op_wdata, rpc_n, epc_n;
    logic            op_we, win_ok, found, exc_n;
    logic [1:0]      n_found, n_ret, m_ret;
    logic [GW-1:0]   owb_n;
    win_ev_e         ev_n;

    // index mapping, one mapper per access path
    always_comb begin
        map_w[M_RD]  = rd_idx;
        map_w[M_WR]  = wr_idx;
        map_w[M_SRC] = {2'b00, op_sel[1:0]};
        map_w[M_DST] = {ps_callinc, op_sel[1:0]};
        map_w[M_A0]  = 4'd0;
    end

    for (genvar g = 0; g < NMAP; g++) begin : g_map
        regwin_map #(.NAREG(NAREG)) u_map (
            .base (base_q),
            .widx (map_w[g]),
            .pidx (map_p[g])
        );
    end

    regwin_rel #(.NGRP(NGRP)) u_rel (
        .ws   (ws_q),
        .base (base_q),
        .rel  (rel)
    );

    assign f_raddr[0] = map_p[M_RD];
    assign f_raddr[1] = map_p[M_SRC];
    assign f_raddr[2] = map_p[M_A0];
    assign rd_data    = f_rdata[0];
    assign src_val    = f_rdata[1];
    assign a0_val     = f_rdata[2];

    regwin_file #(.NAREG(NAREG), .XLEN(XLEN), .NRD(3)) u_file (
        .clk   (clk),
        .rst   (rst),
        .raddr (f_raddr),
        .rdata (f_rdata),
        .we_lo (wr_en),
        .wa_lo (map_p[M_WR]),
        .wd_lo (wr_data),
        .we_hi (op_we),
        .wa_hi (map_p[M_DST]),
        .wd_hi (op_wdata)
    );

    // operation decode and next state
    always_comb begin
        base_n   = base_q;
        ws_n     = ws_q;
        ev_n     = EV_NONE;
        rpc_n    = '0;
        owb_n    = '0;
        op_we    = 1'b0;
        op_wdata = src_val - (XLEN'(op_imm) << 3);
        win_ok   = ps_woe & ~ps_excm;
        found    = 1'b0;
        n_found  = 2'd0;
        n_ret    = a0_val[XLEN-1 -: 2];
        if (rel[NGRP-1])      m_ret = 2'd1;
        else if (rel[NGRP-2]) m_ret = 2'd2;
        else if (rel[NGRP-3]) m_ret = 2'd3;
        else                  m_ret = 2'd0;

        for (int k = 1; k <= 3; k++) begin
            if (!found && (k <= int'(op_amt[1:0])) && rel[k]) begin
                found   = 1'b1;
                n_found = 2'(k);
            end
        end

        if (op_valid) begin
            case (op_code)
                OP_ENTRY: begin
                    if (op_sel > 4'd3 || !win_ok) begin
                        ev_n = EV_ILLEGAL;
                    end else begin
                        op_we        = 1'b1;
                        base_n       = base_q + GW'(ps_callinc);
                        ws_n[base_n] = 1'b1;
                    end
                end
                OP_OVCHK: begin
                    if (win_ok && found) begin
                        base_n = base_q + GW'(n_found);
                        owb_n  = base_q;
                        ev_n   = ev_spill(rel[int'(n_found) + 1], rel[int'(n_found) + 2]);
                    end
                end
                OP_RETW: begin
                    if (n_ret == 2'd0 || (m_ret != 2'd0 && m_ret != n_ret) || !win_ok) begin
                        ev_n = EV_ILLEGAL;
                    end else begin
                        rpc_n  = {op_pc[XLEN-1 -: 2], a0_val[XLEN-3:0]};
                        base_n = base_q - GW'(n_ret);
                        if (ws_q[base_n]) begin
                            ws_n[base_q] = 1'b0;
                        end else begin
                            owb_n = base_q;
                            ev_n  = ev_fill(n_ret);
                        end
                    end
                end
                OP_ROTW:    base_n = base_q + op_amt;
                OP_SETBASE: base_n = op_amt;
                OP_RESTORE: base_n = ps_owb;
                OP_MOVSP: begin
                    if (!rel[NGRP-1] && !rel[NGRP-2] && !rel[NGRP-3]) begin
                        ev_n = EV_ALLOCA;
                    end
                end
                default: ;
            endcase
        end

        exc_n = ev_is_exc(ev_n);
        epc_n = exc_n ? op_pc : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q    <= '0;
            ws_q      <= NGRP'(1);
            res_valid <= 1'b0;
            ev_code   <= EV_NONE;
            ret_pc    <= '0;
            epc_out   <= '0;
            set_excm  <= 1'b0;
            owb_out   <= '0;
        end else begin
            base_q    <= base_n;
            ws_q      <= ws_n;
            res_valid <= op_valid;
            ev_code   <= ev_n;
            ret_pc    <= rpc_n;
            epc_out   <= epc_n;
            set_excm  <= exc_n;
            owb_out   <= owb_n;
        end
    end

    assign window_base  = base_q;
    assign window_start = ws_q;

endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
    parameter int NAREG = 64,
    localparam int NGRP = NAREG / 4,
    localparam int GW   = $clog2(NGRP)
) (
    input logic            clk,
    input logic            rst,
    input logic            op_valid,
    input logic [2:0]      op_code,
    input logic [3:0]      op_sel,
    input logic [GW-1:0]   op_amt,
    input logic            ps_woe,
    input logic            ps_excm,
    input logic            res_valid,
    input logic [3:0]      ev_code,
    input logic [GW-1:0]   window_base,
    input logic [NGRP-1:0] window_start
);
    logic win_ok, back_clear;
    assign win_ok = ps_woe & ~ps_excm;
    assign back_clear = !window_start[window_base - GW'(1)] &&
                        !window_start[window_base - GW'(2)] &&
                        !window_start[window_base - GW'(3)];

    AST_RESULT_AFTER_OP: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid); // R11
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(op_valid)); // R11
    AST_ENTRY_BAD_SEL: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd1 && op_sel > 4'd3) |=> (ev_code == 4'd1 && $stable(window_base))); // R3
    AST_ENTRY_MARKS_FRAME: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd1 && op_sel <= 4'd3 && win_ok) |=> window_start[window_base]); // R4
    AST_PROBE_GATED: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd2 && !win_ok) |=> (ev_code == 4'd0 && $stable(window_base) && $stable(window_start))); // R5
    AST_ROTATE_DELTA: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd4) |=> (window_base == GW'($past(window_base) + $past(op_amt)))); // R9
    AST_ALLOCA_FAULT: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd7 && back_clear) |=> (ev_code == 4'd8)); // R10
endmodule

bind regwin_ctrl regwin_chk #(.NAREG(NAREG)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .op_sel       (op_sel),
    .op_amt       (op_amt),
    .ps_woe       (ps_woe),
    .ps_excm      (ps_excm),
    .res_valid    (res_valid),
    .ev_code      (ev_code),
    .window_base  (window_base),
    .window_start (window_start)
);

// File: tb/regwin_ctrl_tb_top.sv
`timescale 1ns/1ps
module regwin_ctrl_tb_top;
    localparam int NAREG = 64;
    localparam int NGRP  = NAREG / 4;
    localparam int GW    = $clog2(NGRP);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_valid = 1'b0;
    logic [2:0] op_code = '0;
    logic [3:0] op_sel = '0;
    logic [11:0] op_imm = '0;
    logic [GW-1:0] op_amt = '0;
    logic [31:0] op_pc = '0;
    logic ps_woe = 1'b0, ps_excm = 1'b0;
    logic [1:0] ps_callinc = '0;
    logic [GW-1:0] ps_owb = '0;
    logic wr_en = 1'b0;
    logic [3:0] wr_idx = '0, rd_idx = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data, ret_pc, epc_out;
    logic res_valid, set_excm;
    logic [3:0] ev_code;
    logic [GW-1:0] owb_out, window_base;
    logic [NGRP-1:0] window_start;

    int n_chk = 0, n_fail = 0;
    int m_base;
    logic [NGRP-1:0] m_ws;
    logic [31:0] m_phys [NAREG];

    always #2 clk = ~clk;

    regwin_ctrl #(.NAREG(NAREG)) dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_sel(op_sel),
        .op_imm(op_imm), .op_amt(op_amt), .op_pc(op_pc), .ps_woe(ps_woe), .ps_excm(ps_excm),
        .ps_callinc(ps_callinc), .ps_owb(ps_owb), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .res_valid(res_valid),
        .ev_code(ev_code), .ret_pc(ret_pc), .epc_out(epc_out), .set_excm(set_excm),
        .owb_out(owb_out), .window_base(window_base), .window_start(window_start)
    );

    function automatic int pmap(int b, int r);
        return (b * 4 + r) % NAREG;
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic rd_chk(string tag, int idx);
        rd_idx = 4'(idx);
        #1;
        chk(tag, "rd_data", rd_data, m_phys[pmap(m_base, idx)]);
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic run_op(int op, int sel, int imm, int amt, logic [31:0] pc, bit woe, bit excm,
                          int cinc, int powb, bit we, int widx, logic [31:0] wdata);
        int old, ev, n, mm, nb;
        bit ok;
        logic [31:0] src, a0, rp, ep, ow;
        string tag;
        op_valid = 1'b1; op_code = 3'(op); op_sel = 4'(sel); op_imm = 12'(imm);
        op_amt = GW'(amt); op_pc = pc; ps_woe = woe; ps_excm = excm;
        ps_callinc = 2'(cinc); ps_owb = GW'(powb); wr_en = we; wr_idx = 4'(widx); wr_data = wdata;
        old = m_base; ok = woe && !excm; ev = 0; rp = 0; ow = 0; tag = "R11";
        src = m_phys[pmap(old, sel % 4)];
        a0  = m_phys[pmap(old, 0)];
        if (we) m_phys[pmap(old, widx)] = wdata;
        case (op)
            1: begin
                if (sel > 3 || !ok) begin ev = 1; tag = "R3"; end
                else begin
                    tag = "R4";
                    m_phys[pmap(old, cinc * 4 + sel)] = src - (32'(imm) << 3);
                    m_base = (old + cinc) % NGRP;
                    m_ws[m_base] = 1'b1;
                end
            end
            2: begin
                tag = "R5";
                if (ok) begin
                    n = 0;
                    for (int k = 1; k <= 3; k++)
                        if (n == 0 && k <= (amt % 4) && m_ws[(old + k) % NGRP]) n = k;
                    if (n != 0) begin
                        tag = "R6";
                        mm = (old + n) % NGRP;
                        m_base = mm; ow = old;
                        ev = m_ws[(mm + 1) % NGRP] ? 2 : (m_ws[(mm + 2) % NGRP] ? 3 : 4);
                    end
                end
            end
            3: begin
                n = int'(a0[31:30]);
                mm = m_ws[(old + NGRP - 1) % NGRP] ? 1 : m_ws[(old + NGRP - 2) % NGRP] ? 2 :
                     m_ws[(old + NGRP - 3) % NGRP] ? 3 : 0;
                if (n == 0 || (mm != 0 && mm != n) || !ok) begin ev = 1; tag = "R7"; end
                else begin
                    tag = "R8";
                    rp = {pc[31:30], a0[29:0]};
                    nb = (old + NGRP - n) % NGRP;
                    m_base = nb;
                    if (m_ws[nb]) m_ws[old] = 1'b0;
                    else begin ev = 4 + n; ow = old; end
                end
            end
            4: begin tag = "R9"; m_base = (old + amt) % NGRP; end
            5: begin tag = "R9"; m_base = amt % NGRP; end
            6: begin tag = "R9"; m_base = powb % NGRP; end
            7: begin tag = "R10"; if (!m_ws[(old + NGRP - 1) % NGRP] && !m_ws[(old + NGRP - 2) % NGRP] &&
                                       !m_ws[(old + NGRP - 3) % NGRP]) ev = 8; end
            default: ;
        endcase
        ep = (ev != 0) ? pc : 32'd0;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0; wr_en = 1'b0;
        chk("R11", "res_valid", res_valid, 1);
        chk(tag, "ev_code", ev_code, ev);
        chk(tag, "ret_pc", ret_pc, rp);
        chk("R11", "epc_out", epc_out, ep);
        chk("R11", "set_excm", set_excm, (ev != 0));
        chk(tag, "owb_out", owb_out, ow);
        chk(tag, "window_base", window_base, m_base);
        chk(tag, "window_start", window_start, m_ws);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        m_base = 0; m_ws = NGRP'(1);
        for (int i = 0; i < NAREG; i++) m_phys[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "window_base", window_base, 0);
        chk("R1", "window_start", window_start, 1);
        chk("R1", "res_valid", res_valid, 0);
        rd_chk("R1", 7);
        @(negedge clk);
        chk("R11", "idle res_valid", res_valid, 0);

        // R2 mapping with wraparound
        run_op(0, 0, 0, 0, 32'h100, 1, 0, 0, 0, 1, 5, 32'hA5A5_0005);
        run_op(5, 0, 0, 15, 32'h104, 1, 0, 0, 0, 0, 0, 0);
        rd_chk("R2", 9);
        run_op(5, 0, 0, 0, 32'h108, 1, 0, 0, 0, 0, 0, 0);
        // R3 illegal entries
        run_op(1, 4, 3, 0, 32'h200, 1, 0, 1, 0, 0, 0, 0);
        run_op(1, 1, 3, 0, 32'h204, 0, 0, 1, 0, 0, 0, 0);
        run_op(1, 1, 3, 0, 32'h206, 1, 1, 1, 0, 0, 0, 0);
        // R4 legal entry
        run_op(1, 1, 2, 0, 32'h208, 1, 0, 1, 0, 0, 0, 0);
        rd_chk("R4", 1);
        // R12 collision of port write and entry write
        run_op(1, 2, 1, 0, 32'h20C, 1, 0, 2, 0, 1, 10, 32'h1234_5678);
        rd_chk("R12", 2);
        // R5 probe gated and width zero
        run_op(2, 0, 0, 3, 32'h300, 1, 1, 0, 0, 0, 0, 0);
        run_op(2, 0, 0, 0, 32'h304, 1, 0, 0, 0, 0, 0, 0);
        // R6 probe fires (bits 0,1,3 live from base 0 -> spill 8)
        run_op(5, 0, 0, 0, 32'h308, 1, 0, 0, 0, 0, 0, 0);
        run_op(2, 0, 0, 3, 32'h30C, 1, 0, 0, 0, 0, 0, 0);
        // R8 legal return with n=1
        run_op(0, 0, 0, 0, 32'h400, 1, 0, 0, 0, 1, 0, 32'h4000_0ABC);
        run_op(3, 0, 0, 0, 32'hC000_0404, 1, 0, 0, 0, 0, 0, 0);
        // R7 return with n=0
        run_op(0, 0, 0, 0, 32'h408, 1, 0, 0, 0, 1, 0, 32'h0000_0111);
        run_op(3, 0, 0, 0, 32'h40C, 1, 0, 0, 0, 0, 0, 0);
        // R10 alloca fault far from live frames
        run_op(5, 0, 0, 9, 32'h500, 1, 0, 0, 0, 0, 0, 0);
        run_op(7, 0, 0, 0, 32'h504, 1, 0, 0, 0, 0, 0, 0);
        // R9 rotate and restore
        run_op(4, 0, 0, 11, 32'h600, 1, 0, 0, 0, 0, 0, 0);
        run_op(6, 0, 0, 0, 32'h604, 1, 0, 0, 3, 0, 0, 0);

        // random mix, port writes left running alongside operations (R12)
        for (int i = 0; i < 800; i++) begin
            int op, sel, amt;
            op  = $urandom_range(0, 7);
            sel = ($urandom_range(0, 9) == 0) ? 4 : $urandom_range(0, 3);
            amt = $urandom_range(0, NGRP - 1);
            run_op(op, sel, $urandom_range(0, 4095), amt, $urandom,
                   ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) == 0),
                   $urandom_range(0, 3), $urandom_range(0, NGRP - 1),
                   ($urandom_range(0, 1) == 1), $urandom_range(0, 15), $urandom);
            if (i % 8 == 0) rd_chk("R2", $urandom_range(0, 15));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule